// File: doc/BRIEF.md
# Station Address Loader and Setup Frame Builder

This block recovers a 48-bit station address from a serial configuration memory. It then turns that address into the 192-byte address-filter setup frame that the transmit engine sends when the link comes up. A single start pulse runs the whole job. The block asks the memory master for three consecutive 16-bit words, one request at a time. It checks the words with a sum test, then publishes the address with a valid flag.

After the check, the block writes the frame into a byte buffer at one byte per cycle. It finishes with a one-cycle done pulse. The pulse carries the frame length and a flag that marks the frame as a setup frame, so the descriptor logic downstream can queue it. Descriptor handling itself is not part of this block.

If the sum test rejects the address, the address output reads zero and the valid flag stays low. The frame is still written, with zero bytes in the address slots.

Top module: `station_addr_loader`

## Requirements
- R1: After an accepted start, the block reads memory word addresses 0x0A, 0x0B and 0x0C, in that order. It holds `ee_req_o` high with a stable `ee_addr_o` until the cycle in which `ee_gnt_i` is high, and it captures `ee_data_i` in that cycle. It makes exactly three reads per load.
- R2: Each word holds two address bytes, low byte first. `mac_addr_o[47:40]` is bits 7:0 of word 0x0A and `mac_addr_o[39:32]` is bits 15:8 of word 0x0A. The same pattern continues down to `mac_addr_o[7:0]`, which is bits 15:8 of word 0x0C.
- R3: The three words are added as unsigned values with no truncation, which needs 18 bits. A sum of 0 or of 0x2FFFD marks the address invalid. An invalid address forces `mac_addr_o` to zero and keeps `mac_valid_o` low. Any other sum is valid, including sums of 0x10000 and above.
- R4: An accepted start clears `mac_valid_o` and `mac_addr_o` on the next clock edge. `mac_valid_o` rises only once the third word is captured and the check passes.
- R5: The frame is written as 192 byte writes (`frm_we_o` high) at offsets 0 to 191. The offsets are consecutive and come one per cycle, starting the cycle after the address is published.
- R6: Frame offsets 0,1 hold address bytes 0,1. Offsets 4,5 hold bytes 2,3, and offsets 8,9 hold bytes 4,5. Byte n here is the n-th byte of R2, most significant first. Every other offset holds 0xFF.
- R7: `done_o` is high for exactly one cycle, the cycle after the byte at offset 191 is written. In that cycle `desc_len_o` is 192 and `desc_setup_o` is 1. In every other cycle both read 0.
- R8: A start pulse that arrives while a load is in progress is ignored. It causes no extra reads, no extra writes and no second done pulse.
- R9: After reset, `ee_req_o`, `frm_we_o`, `done_o` and `mac_valid_o` are low, and `mac_addr_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a load; ignored unless idle |
| done_o | output | 1 | One-cycle pulse when the frame is complete |
| ee_req_o | output | 1 | Read request to the memory master |
| ee_addr_o | output | 8 | Word address of the pending read |
| ee_gnt_i | input | 1 | Read completed; data valid this cycle |
| ee_data_i | input | 16 | Word returned by the memory master |
| mac_addr_o | output | 48 | Station address, first byte in the top bits |
| mac_valid_o | output | 1 | Station address passed the check |
| frm_we_o | output | 1 | Frame byte write strobe |
| frm_addr_o | output | 8 | Frame byte offset |
| frm_data_o | output | 8 | Frame byte value |
| desc_len_o | output | 8 | Frame length, valid with done_o |
| desc_setup_o | output | 1 | Setup-frame flag, valid with done_o |

## Verification
A wrong word index in the fetch sequencer shows up right away as an unexpected address on `ee_addr_o` at the next request, or as a fourth read. A fault in the sum test or in the byte order is visible at the address outputs one cycle after the last grant. It also shows in the address slots of the first ten frame bytes written after that. A stuck or skipping byte counter puts a wrong offset, a missing write or a misplaced done pulse on the write port within 192 cycles. The bench compares every write against a queue of expected bytes as it happens, so the first bad byte is reported at the cycle it appears.

// File: rtl/sal_pkg.sv
// Package: shared types for the station address loader.
// Assumes: nothing beyond IEEE 1800-2017.
package sal_pkg;

    // Top-level sequencing phases.
    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_FETCH = 2'd1,
        LD_FRAME = 2'd2
    } ld_state_e;

    // Bits needed to add n unsigned words of width w without overflow.
    function automatic int sum_width(input int w, input int n);
        return w + ((n > 1) ? $clog2(n) : 0);
    endfunction

endpackage

// File: rtl/sal_word_fetch.sv
// Module: sal_word_fetch
// Reads NUM_WORDS consecutive words from the memory master, starting at
// BASE_WORD. Only one request is outstanding at a time.
// Assumes: go_i is pulsed only while no fetch is running; the master
// returns data in the same cycle as the grant.
module sal_word_fetch #(
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 3,
    parameter int EE_AW     = 8,
    parameter int BASE_WORD = 'h0A
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        go_i,
    output logic                        ee_req_o,
    output logic [EE_AW-1:0]            ee_addr_o,
    input  logic                        ee_gnt_i,
    input  logic [WORD_W-1:0]           ee_data_i,
    output logic [NUM_WORDS*WORD_W-1:0] words_o,
    output logic                        done_o
);
    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);
    localparam logic [EE_AW-1:0] BASE_A   = EE_AW'(BASE_WORD);
    localparam logic [EE_AW-1:0] LAST_A   = EE_AW'(BASE_WORD + NUM_WORDS - 1);

    logic                        req_q;
    logic [IDX_W-1:0]            idx_q;
    logic [NUM_WORDS*WORD_W-1:0] words_q;
    logic                        done_q;

    // Request and capture sequencer: advance one word per grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            idx_q   <= '0;
            words_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go_i) begin
                req_q <= 1'b1;
                idx_q <= '0;
            end else if (req_q && ee_gnt_i) begin
                words_q[idx_q*WORD_W +: WORD_W] <= ee_data_i;
                if (idx_q == LAST_IDX) begin
                    req_q  <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign ee_req_o  = req_q;
    assign ee_addr_o = BASE_A + EE_AW'(idx_q);
    assign words_o   = words_q;
    assign done_o    = done_q;

    // R1: a pending request keeps its address until granted.
    a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req_o && !ee_gnt_i) |=> (ee_req_o && $stable(ee_addr_o)));

    // R1: requests stay inside the address window.
    a_r1_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
        ee_req_o |-> (ee_addr_o >= BASE_A && ee_addr_o <= LAST_A));

    // R1: completion follows the grant of the last word.
    a_r1_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(ee_gnt_i) && $past(ee_addr_o) == LAST_A));

endmodule

// File: rtl/sal_addr_check.sv
// Module: sal_addr_check
// Reorders the fetched words into address bytes, first byte in the top
// bits, and applies the unsigned-sum validity test.
// Assumes: WORD_W is a multiple of 8 and each word is stored low byte first.
module sal_addr_check #(
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 3
) (
    input  logic [NUM_WORDS*WORD_W-1:0] words_i,
    output logic [NUM_WORDS*WORD_W-1:0] addr_o,
    output logic                        ok_o
);
    import sal_pkg::*;

    localparam int BPW        = WORD_W / 8;
    localparam int ADDR_BYTES = NUM_WORDS * BPW;
    localparam int MAC_W      = ADDR_BYTES * 8;
    localparam int SUM_W      = sum_width(WORD_W, NUM_WORDS);
    localparam logic [SUM_W-1:0] ONE_WORD = SUM_W'((64'd1 << WORD_W) - 64'd1);
    localparam logic [SUM_W-1:0] REJECT_HI = SUM_W'(NUM_WORDS) * ONE_WORD;

    logic [SUM_W-1:0] sum_c;

    // Byte reordering: byte k comes from word k/BPW, lane k%BPW.
    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_byte
        assign addr_o[MAC_W-1-8*k -: 8] =
            words_i[(k/BPW)*WORD_W + 8*(k%BPW) +: 8];
    end

    // Full-width unsigned sum of all words.
    always_comb begin
        sum_c = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            sum_c = sum_c + SUM_W'(words_i[w*WORD_W +: WORD_W]);
        end
    end

    assign ok_o = (sum_c != '0) && (sum_c != REJECT_HI);

endmodule

// File: rtl/sal_frame_stream.sv
// Module: sal_frame_stream
// Writes a FRAME_LEN-byte setup frame, one byte per cycle. Each address
// byte pair goes at the start of a 2**STRIDE_LG byte slot; all else is FILL.
// Assumes: addr_i is stable while the stream runs; 2**STRIDE_LG >= WORD_W/8.
module sal_frame_stream #(
    parameter int         FRAME_LEN = 192,
    parameter int         WORD_W    = 16,
    parameter int         NUM_WORDS = 3,
    parameter int         STRIDE_LG = 2,
    parameter logic [7:0] FILL      = 8'hFF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          go_i,
    input  logic [NUM_WORDS*WORD_W-1:0]   addr_i,
    output logic                          we_o,
    output logic [$clog2(FRAME_LEN)-1:0]  waddr_o,
    output logic [7:0]                    wdata_o,
    output logic                          done_o
);
    localparam int BPW    = WORD_W / 8;
    localparam int MAC_W  = NUM_WORDS * WORD_W;
    localparam int IDX_W  = $clog2(FRAME_LEN);
    localparam int STRIDE = 1 << STRIDE_LG;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

    logic             active_q;
    logic [IDX_W-1:0] idx_q;
    logic             done_q;
    int               slot_c;
    int               lane_c;

    // Byte counter: runs from 0 to FRAME_LEN-1, then pulses done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go_i) begin
                active_q <= 1'b1;
                idx_q    <= '0;
            end else if (active_q) begin
                if (idx_q == LAST) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // Byte selection: address byte inside a slot's leading lanes, else fill.
    always_comb begin
        slot_c  = int'(idx_q) >> STRIDE_LG;
        lane_c  = int'(idx_q) & (STRIDE - 1);
        wdata_o = FILL;
        if (slot_c < NUM_WORDS && lane_c < BPW) begin
            wdata_o = addr_i[MAC_W-1-8*(slot_c*BPW+lane_c) -: 8];
        end
    end

    assign we_o    = active_q;
    assign waddr_o = idx_q;
    assign done_o  = done_q;

    // R5: writes come on consecutive cycles at consecutive offsets.
    a_r5_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && waddr_o != LAST) |=> (we_o && waddr_o == $past(waddr_o) + 1'b1));

    // R7: done follows the write of the final offset.
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(we_o) && $past(waddr_o) == LAST));

endmodule

// File: rtl/station_addr_loader.sv
// Module: station_addr_loader (top)
// Fetches the station address, validates it, publishes it, then streams
// the setup frame and reports its length and type with a done pulse.
// Assumes: the memory master serves one read at a time; the frame buffer
// accepts one byte per cycle without back-pressure.
module station_addr_loader #(
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 3,
    parameter int EE_AW     = 8,
    parameter int BASE_WORD = 'h0A,
    parameter int FRAME_LEN = 192,
    parameter int STRIDE_LG = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    output logic                           done_o,
    output logic                           ee_req_o,
    output logic [EE_AW-1:0]               ee_addr_o,
    input  logic                           ee_gnt_i,
    input  logic [WORD_W-1:0]              ee_data_i,
    output logic [NUM_WORDS*WORD_W-1:0]    mac_addr_o,
    output logic                           mac_valid_o,
    output logic                           frm_we_o,
    output logic [$clog2(FRAME_LEN)-1:0]   frm_addr_o,
    output logic [7:0]                     frm_data_o,
    output logic [$clog2(FRAME_LEN+1)-1:0] desc_len_o,
    output logic                           desc_setup_o
);
    import sal_pkg::*;

    localparam int MAC_W = NUM_WORDS * WORD_W;
    localparam int LEN_W = $clog2(FRAME_LEN + 1);

    ld_state_e              state_q;
    logic                   accept_c;
    logic                   fetch_done;
    logic                   frame_done;
    logic [MAC_W-1:0]       words;
    logic [MAC_W-1:0]       addr_chk;
    logic                   addr_ok;
    logic [MAC_W-1:0]       mac_q;
    logic                   valid_q;

    assign accept_c = start_i && (state_q == LD_IDLE);

    sal_word_fetch #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .EE_AW     (EE_AW),
        .BASE_WORD (BASE_WORD)
    ) fetch_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (accept_c),
        .ee_req_o  (ee_req_o),
        .ee_addr_o (ee_addr_o),
        .ee_gnt_i  (ee_gnt_i),
        .ee_data_i (ee_data_i),
        .words_o   (words),
        .done_o    (fetch_done)
    );

    sal_addr_check #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS)
    ) check_i (
        .words_i (words),
        .addr_o  (addr_chk),
        .ok_o    (addr_ok)
    );

    sal_frame_stream #(
        .FRAME_LEN (FRAME_LEN),
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .STRIDE_LG (STRIDE_LG),
        .FILL      (8'hFF)
    ) stream_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (fetch_done),
        .addr_i  (mac_q),
        .we_o    (frm_we_o),
        .waddr_o (frm_addr_o),
        .wdata_o (frm_data_o),
        .done_o  (frame_done)
    );

    // Phase sequencer: idle -> fetch -> frame -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_IDLE;
        end else begin
            unique case (state_q)
                LD_IDLE:  if (accept_c)   state_q <= LD_FETCH;
                LD_FETCH: if (fetch_done) state_q <= LD_FRAME;
                LD_FRAME: if (frame_done) state_q <= LD_IDLE;
                default:                  state_q <= LD_IDLE;
            endcase
        end
    end

    // Address publication: cleared on start, loaded once the fetch ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mac_q   <= '0;
            valid_q <= 1'b0;
        end else if (accept_c) begin
            mac_q   <= '0;
            valid_q <= 1'b0;
        end else if (fetch_done) begin
            mac_q   <= addr_ok ? addr_chk : '0;
            valid_q <= addr_ok;
        end
    end

    assign mac_addr_o   = mac_q;
    assign mac_valid_o  = valid_q;
    assign done_o       = frame_done;
    assign desc_setup_o = frame_done;
    assign desc_len_o   = frame_done ? LEN_W'(FRAME_LEN) : '0;

    // R3: an unvalidated address always reads as zero.
    a_r3_zero_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !mac_valid_o |-> (mac_addr_o == '0));

    // R4: valid rises only at the end of a fetch phase.
    a_r4_valid_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mac_valid_o) |-> ($past(state_q) == LD_FETCH));

    // R8: no memory request or frame write while idle.
    a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_IDLE) |-> (!ee_req_o && !frm_we_o));

endmodule

// File: tb/station_addr_loader_tb_top.sv
module station_addr_loader_tb_top;

    localparam int FRAME_LEN = 192;
    localparam int BASE      = 'h0A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        done_o;
    logic        ee_req_o;
    logic [7:0]  ee_addr_o;
    logic        ee_gnt_i = 1'b0;
    logic [15:0] ee_data_i = '0;
    logic [47:0] mac_addr_o;
    logic        mac_valid_o;
    logic        frm_we_o;
    logic [7:0]  frm_addr_o;
    logic [7:0]  frm_data_o;
    logic [7:0]  desc_len_o;
    logic        desc_setup_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [15:0] mem [3];
    int          lat_cfg = 0;
    int          lat_cnt = 0;
    int          rd_cnt  = 0;
    int          done_cnt = 0;
    logic [15:0] exp_q [$];   // {offset, data}

    always #4 clk = ~clk;   // 125 MHz

    station_addr_loader dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .done_o       (done_o),
        .ee_req_o     (ee_req_o),
        .ee_addr_o    (ee_addr_o),
        .ee_gnt_i     (ee_gnt_i),
        .ee_data_i    (ee_data_i),
        .mac_addr_o   (mac_addr_o),
        .mac_valid_o  (mac_valid_o),
        .frm_we_o     (frm_we_o),
        .frm_addr_o   (frm_addr_o),
        .frm_data_o   (frm_data_o),
        .desc_len_o   (desc_len_o),
        .desc_setup_o (desc_setup_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Memory master model: grant after lat_cfg idle cycles, check address order (R1).
    always @(negedge clk) begin
        cycles++;
        if (!rst_n) begin
            ee_gnt_i = 1'b0;
            lat_cnt  = 0;
        end else if (ee_gnt_i) begin
            ee_gnt_i = 1'b0;
        end else if (ee_req_o) begin
            if (lat_cnt >= lat_cfg) begin
                check(ee_addr_o == 8'(BASE + rd_cnt), "R1", "read address",
                      64'(ee_addr_o), 64'(BASE + rd_cnt));
                if (ee_addr_o >= 8'(BASE) && ee_addr_o < 8'(BASE + 3))
                    ee_data_i = mem[ee_addr_o - 8'(BASE)];
                else
                    ee_data_i = 16'h0;
                ee_gnt_i = 1'b1;
                rd_cnt++;
                lat_cnt = 0;
            end else begin
                lat_cnt++;
            end
        end
    end

    // Scoreboard monitor: every frame write is popped and compared (R5, R6).
    always @(negedge clk) begin
        if (rst_n && done_o) done_cnt++;
        if (rst_n && frm_we_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", "unexpected write at offset", 64'(frm_addr_o), 64'hFFFF);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(frm_addr_o == e[15:8], "R5", "write offset",
                      64'(frm_addr_o), 64'(e[15:8]));
                check(frm_data_o == e[7:0], "R6", "write data",
                      64'(frm_data_o), 64'(e[7:0]));
            end
        end
    end

    // Driver: load memory, queue the expected frame, run one load, check results.
    task automatic run_load(input logic [15:0] w0, input logic [15:0] w1,
                            input logic [15:0] w2, input int lat, input bit extra_starts);
        logic [17:0] sum;
        logic [7:0]  b [6];
        bit          ok;
        logic [47:0] exp_mac;
        int          done_before;
        mem[0] = w0; mem[1] = w1; mem[2] = w2;
        lat_cfg = lat;
        rd_cnt  = 0;
        sum = 18'(w0) + 18'(w1) + 18'(w2);
        ok  = (sum != 18'h0) && (sum != 18'h2FFFD);
        b[0] = w0[7:0]; b[1] = w0[15:8];
        b[2] = w1[7:0]; b[3] = w1[15:8];
        b[4] = w2[7:0]; b[5] = w2[15:8];
        if (!ok) for (int i = 0; i < 6; i++) b[i] = 8'h00;
        exp_mac = {b[0], b[1], b[2], b[3], b[4], b[5]};
        for (int i = 0; i < FRAME_LEN; i++) begin
            int slot = i >> 2;
            int lane = i & 3;
            logic [7:0] d = (slot < 3 && lane < 2) ? b[slot*2+lane] : 8'hFF;
            exp_q.push_back({8'(i), d});
        end
        done_before = done_cnt;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(mac_valid_o == 1'b0, "R4", "valid cleared after start", 64'(mac_valid_o), 0);
        check(mac_addr_o == 48'h0, "R4", "address cleared after start", 64'(mac_addr_o), 0);
        if (extra_starts) begin
            start_i = 1'b1;               // during fetch (R8)
            @(negedge clk);
            start_i = 1'b0;
            while (!frm_we_o) @(negedge clk);
            repeat (20) @(negedge clk);
            start_i = 1'b1;               // during frame (R8)
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        check(desc_len_o == 8'd192, "R7", "length with done", 64'(desc_len_o), 192);
        check(desc_setup_o == 1'b1, "R7", "setup flag with done", 64'(desc_setup_o), 1);
        check(exp_q.size() == 0, "R5", "bytes left unwritten", 64'(exp_q.size()), 0);
        check(rd_cnt == 3, "R1", "reads per load", 64'(rd_cnt), 3);
        check(mac_addr_o == exp_mac, "R2", "station address", 64'(mac_addr_o), 64'(exp_mac));
        check(mac_valid_o == ok, "R3", "valid flag", 64'(mac_valid_o), 64'(ok));
        @(negedge clk);
        check(done_o == 1'b0, "R7", "done pulse width", 64'(done_o), 0);
        check(desc_setup_o == 1'b0 && desc_len_o == 8'd0, "R7", "descriptor idle",
              64'({desc_setup_o, desc_len_o}), 0);
        repeat (6) @(negedge clk);
        check(done_cnt - done_before == 1, "R8", "done pulses per load",
              64'(done_cnt - done_before), 1);
        check(!ee_req_o && !frm_we_o && rd_cnt == 3, "R8", "quiet after load",
              64'({ee_req_o, frm_we_o}), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        wait (cycles > 100000);
        errors++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        repeat (4) @(negedge clk);
        check(!ee_req_o && !frm_we_o && !done_o, "R9", "outputs idle in reset",
              64'({ee_req_o, frm_we_o, done_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mac_valid_o == 1'b0 && mac_addr_o == 48'h0, "R9", "address after reset",
              64'(mac_addr_o), 0);
        check(!ee_req_o && !frm_we_o && !done_o, "R9", "outputs after reset",
              64'({ee_req_o, frm_we_o, done_o}), 0);

        run_load(16'h3412, 16'h7856, 16'hBC9A, 0, 1'b0);   // R2 R6 normal
        run_load(16'h0000, 16'h0000, 16'h0000, 2, 1'b0);   // R3 zero sum
        run_load(16'hFFFF, 16'hFFFF, 16'hFFFF, 1, 1'b0);   // R3 all-ones sum
        run_load(16'hFFFF, 16'hFFFF, 16'hFFFE, 0, 1'b0);   // R3 just below reject
        run_load(16'h8000, 16'h8000, 16'h0000, 1, 1'b0);   // R3 carry past 16 bits
        run_load(16'hA5C3, 16'h0F1E, 16'h2D4B, 3, 1'b1);   // R8 extra starts
        run_load(16'h0001, 16'h0000, 16'h0000, 0, 1'b0);   // R3 smallest valid

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule